// File: doc/BRIEF.md
# Pin Control Register Bank with Fixed Interrupt Routing

This block holds one byte-wide control register for each of 36 general-purpose pins, reached through a small synchronous register bus with byte addressing. Each register carries an output-enable flag, an output value and a sampled input level. The sampled level has two possible sources. When software writes the register with the output enable set, the level is a copy of the driven value. When the external input for that pin changes, the level takes the new external value. The low part of the address window is a bank of eight level registers that can only be read.

Two pins are wired to interrupt outputs with fixed meanings. Pin 1 raises its interrupt while its sampled level is low, and it comes out of reset with the level high. Pin 9 drives its interrupt high while its level is high. A separate request input forces pin 9 high for one clock and then low, so the interrupt sees one short pulse. When an external input changes on a pin that is configured as an output, the block reports the clash on a one-cycle error flag.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every pin register reads 0x00 except pin 1, which reads 0x02. The interrupt outputs irq_pin1 and irq_pin9 and the error flag drive_err are all low.
- R2: Addresses 0 to 7 always read 0x00. A write to any of them changes no register.
- R3: Address 8+k reads and writes pin register k, for k from 0 to 35. Addresses 44 to 63 read 0x00, and a write to any of them changes no register.
- R4: A write stores bits 7..2 and bit 0 of the data. Bit 1 of the written data is discarded. If bit 2 (output enable) of the data is 1, bit 1 (level) becomes bit 0 (output value) of the data. If bit 2 is 0, the level keeps its old value. The new contents are readable in the cycle after the write edge.
- R5: When pin_in[k] differs from its value at the previous clock edge, bit 1 of register k takes the new value at that edge, and the other bits do not change. An input that stays stable changes nothing.
- R6: When an external input changes on a pin whose register has bit 2 set, drive_err is high for exactly one cycle after that edge. The level bit still updates.
- R7: irq_pin1 is high exactly while bit 1 of pin register 1 is 0.
- R8: irq_pin9 is high exactly while bit 1 of pin register 9 is 1.
- R9: A rising edge on nmi_req sets bit 1 of pin 9 to 1 for exactly one cycle and then clears it to 0. This takes precedence over writes and input changes. Holding nmi_req high produces no further pulse.
- R10: When a write and an input change hit the same pin in the same cycle, the write sets bits 7..2 and bit 0. For bit 1, a write with the output enable set wins. Otherwise the input change sets bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address in the register window |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational from current state |
| pin_in | input | 36 | External input level per pin |
| nmi_req | input | 1 | Pulse request for pin 9, acts on its rising edge |
| irq_pin1 | output | 1 | Active-high interrupt, asserted while pin 1's level is low |
| irq_pin9 | output | 1 | Interrupt following pin 9's level |
| drive_err | output | 1 | One-cycle flag: input changed on an output-enabled pin |

## Verification
A bus write and an external input change can land on the same pin register in one cycle, and they compete for the level bit. The bench drives the write strobe and the toggled pin_in bit before the same clock edge. It does this once with the output enable clear, where the input change must set the level, and once with it set, where the written output value must set the level. In both cases it reads the register back in the next cycle. It also checks that the one-cycle NMI pulse on pin 9 comes out whole while nmi_req is held high.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // bit positions inside a pin control byte
  localparam int BIT_OUT = 0;
  localparam int BIT_LVL = 1;
  localparam int BIT_OE  = 2;

  localparam logic [7:0] LVL_MASK = 8'h02;

  typedef logic [7:0] pin_byte_t;
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
#(
  parameter pin_byte_t RST_VAL = 8'h00
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  pin_byte_t wr_data,
  input  logic      ext_chg,
  input  logic      ext_val,
  input  logic      force_hi,
  input  logic      force_lo,
  output pin_byte_t q
);
  pin_byte_t r;
  logic      forced;

  assign forced = force_hi | force_lo;
  assign q      = r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r <= RST_VAL;
    end else begin
      if (wr_en) begin
        r[7:BIT_OE]  <= wr_data[7:BIT_OE];
        r[BIT_OUT]   <= wr_data[BIT_OUT];
      end
      if (force_hi)
        r[BIT_LVL] <= 1'b1;
      else if (force_lo)
        r[BIT_LVL] <= 1'b0;
      else if (wr_en && wr_data[BIT_OE])
        r[BIT_LVL] <= wr_data[BIT_OUT];
      else if (ext_chg)
        r[BIT_LVL] <= ext_val;
    end
  end

  // R4
  wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q[7:2] == $past(wr_data[7:2])) && (q[0] == $past(wr_data[0])));

  // R4
  oe_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_OE] && !forced) |=> q[BIT_LVL] == $past(wr_data[BIT_OUT]));

  // R5
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_chg && !wr_en && !forced) |=> q[BIT_LVL] == $past(ext_val));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ext_chg && !forced) |=> $stable(q));
endmodule

// File: rtl/gpio_in_sense.sv
module gpio_in_sense #(
  parameter int NUM_PINS = 36,
  parameter logic [NUM_PINS-1:0] RST_VEC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] oe,
  output logic [NUM_PINS-1:0] chg,
  output logic                drive_err
);
  logic [NUM_PINS-1:0] last_q;

  assign chg = pin_in ^ last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= RST_VEC;
      drive_err <= 1'b0;
    end else begin
      last_q    <= pin_in;
      drive_err <= |(chg & oe);
    end
  end

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(chg & oe)) |=> !drive_err);

  // R5
  quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pin_in) |-> (chg == '0));
endmodule

// File: rtl/gpio_nmi_pulse.sv
module gpio_nmi_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic set_hi,
  output logic set_lo
);
  logic req_q;

  assign set_hi = req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      set_lo <= 1'b0;
    end else begin
      req_q  <= req;
      set_lo <= set_hi;
    end
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hi |=> !set_hi);
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 36,
  parameter int NUM_LEVEL  = 8,
  parameter int ADDR_W     = 6,
  parameter int IRQ_LO_PIN = 1,
  parameter int NMI_PIN    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                nmi_req,
  output logic                irq_pin1,
  output logic                irq_pin9,
  output logic                drive_err
);
  localparam int PIN_BASE = NUM_LEVEL;
  localparam int PIN_END  = NUM_LEVEL + NUM_PINS;
  localparam logic [NUM_PINS-1:0] EXT_RST = NUM_PINS'(1) << IRQ_LO_PIN;

  pin_byte_t           pin_q [NUM_PINS];
  logic [NUM_PINS-1:0] oe_vec;
  logic [NUM_PINS-1:0] chg_vec;
  pin_byte_t           wr_clean;
  logic                nmi_hi, nmi_lo;
  logic [ADDR_W-1:0]   pin_idx;

  assign wr_clean = bus_wdata & ~LVL_MASK;

  gpio_nmi_pulse u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (nmi_req),
    .set_hi (nmi_hi),
    .set_lo (nmi_lo)
  );

  gpio_in_sense #(
    .NUM_PINS (NUM_PINS),
    .RST_VEC  (EXT_RST)
  ) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .oe        (oe_vec),
    .chg       (chg_vec),
    .drive_err (drive_err)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam pin_byte_t CELL_RST = (i == IRQ_LO_PIN) ? LVL_MASK : 8'h00;
    logic wr_hit, f_hi, f_lo;

    assign wr_hit = bus_we && (bus_addr == ADDR_W'(PIN_BASE + i));

    if (i == NMI_PIN) begin : g_nmi
      assign f_hi = nmi_hi;
      assign f_lo = nmi_lo;
    end else begin : g_plain
      assign f_hi = 1'b0;
      assign f_lo = 1'b0;
    end

    gpio_pin_cell #(.RST_VAL(CELL_RST)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit),
      .wr_data  (wr_clean),
      .ext_chg  (chg_vec[i]),
      .ext_val  (pin_in[i]),
      .force_hi (f_hi),
      .force_lo (f_lo),
      .q        (pin_q[i])
    );

    assign oe_vec[i] = pin_q[i][BIT_OE];
  end

  assign pin_idx = bus_addr - ADDR_W'(PIN_BASE);

  always_comb begin
    bus_rdata = 8'h00;
    if (int'(bus_addr) >= PIN_BASE && int'(bus_addr) < PIN_END)
      bus_rdata = pin_q[pin_idx];
  end

  assign irq_pin1 = ~pin_q[IRQ_LO_PIN][BIT_LVL];
  assign irq_pin9 =  pin_q[NMI_PIN][BIT_LVL];

  // R9
  nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nmi_hi)) |-> irq_pin9);

  // R9
  nmi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nmi_lo)) |-> !irq_pin9);

  // R2
  level_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) < PIN_BASE) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_gpio_regbank.sv
`timescale 1ns/1ps
module test_gpio_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [35:0] pin_in = 36'h2;
  logic        nmi_req = 1'b0;
  logic        irq_pin1, irq_pin9, drive_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int         kind;   // 0 rdata, 1 irq_pin1, 2 irq_pin9, 3 drive_err
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  gpio_regbank i_gpio_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .nmi_req   (nmi_req),
    .irq_pin1  (irq_pin1),
    .irq_pin9  (irq_pin9),
    .drive_err (drive_err)
  );

  // monitor: compare one queued item per cycle, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {7'b0, irq_pin1};
        2: act = {7'b0, irq_pin9};
        default: act = {7'b0, drive_err};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    step();
  endtask

  task automatic exp_sig(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {7'b0, e}; it.tag = tag;
    sb.push_back(it);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    exp_rd(6'd9, 8'h02, "R1 pin1 reset");
    exp_rd(6'd8, 8'h00, "R1 pin0 reset");
    exp_sig(1, 1'b0, "R1 irq_pin1 reset");
    exp_sig(2, 1'b0, "R1 irq_pin9 reset");
    exp_sig(3, 1'b0, "R1 drive_err reset");

    // R2 level bank read-only
    wr(6'd3, 8'hFF);
    exp_rd(6'd3, 8'h00, "R2 level addr after write");
    exp_rd(6'd0, 8'h00, "R2 level addr 0");
    exp_rd(6'd8, 8'h00, "R2 pin0 untouched");

    // R4 write field rules
    wr(6'd12, 8'h05);
    exp_rd(6'd12, 8'h07, "R4 oe copy of out");
    wr(6'd12, 8'h01);
    exp_rd(6'd12, 8'h03, "R4 level kept with oe clear");
    wr(6'd13, 8'hFA);
    exp_rd(6'd13, 8'hF8, "R4 data bit1 discarded");
    wr(6'd12, 8'h04);
    exp_rd(6'd12, 8'h04, "R4 oe copy low");

    // R3 mapping and out-of-window
    wr(6'd44, 8'hFF);
    wr(6'd63, 8'hFF);
    exp_rd(6'd44, 8'h00, "R3 addr 44 reads zero");
    exp_rd(6'd63, 8'h00, "R3 addr 63 reads zero");
    exp_rd(6'd43, 8'h00, "R3 pin35 untouched");
    wr(6'd43, 8'h81);
    exp_rd(6'd43, 8'h81, "R3 pin35 write");

    // R5 external input follow
    pin_in[7] = 1'b1;
    step();
    exp_rd(6'd15, 8'h02, "R5 input rise");
    exp_rd(6'd15, 8'h02, "R5 stable input");
    pin_in[7] = 1'b0;
    step();
    exp_rd(6'd15, 8'h00, "R5 input fall");
    exp_sig(3, 1'b0, "R5 no error on plain input");

    // R6 input change on output pin (pin4 holds 0x04)
    pin_in[4] = 1'b1;
    step();
    exp_sig(3, 1'b1, "R6 error pulse");
    exp_sig(3, 1'b0, "R6 error one cycle");
    exp_rd(6'd12, 8'h06, "R6 level still updates");

    // R7 active-low interrupt on pin 1
    pin_in[1] = 1'b0;
    step();
    exp_sig(1, 1'b1, "R7 irq asserted on low");
    exp_rd(6'd9, 8'h00, "R7 pin1 level low");
    pin_in[1] = 1'b1;
    step();
    exp_sig(1, 1'b0, "R7 irq released on high");

    // R8 pin 9 level interrupt
    pin_in[9] = 1'b1;
    step();
    exp_sig(2, 1'b1, "R8 irq9 high");
    exp_rd(6'd17, 8'h02, "R8 pin9 level");
    pin_in[9] = 1'b0;
    step();
    exp_sig(2, 1'b0, "R8 irq9 low");

    // R9 one-shot pulse, request held high
    nmi_req = 1'b1;
    step();
    exp_sig(2, 1'b1, "R9 pulse high");
    exp_sig(2, 1'b0, "R9 pulse ends");
    exp_sig(2, 1'b0, "R9 no repeat while held");
    exp_rd(6'd17, 8'h00, "R9 pin9 level after pulse");
    nmi_req = 1'b0;
    step();

    // R10 same-cycle write and input change
    bus_addr = 6'd14; bus_wdata = 8'h00; bus_we = 1'b1; pin_in[6] = 1'b1;
    step();
    bus_we = 1'b0;
    exp_rd(6'd14, 8'h02, "R10 input wins level with oe clear");
    bus_addr = 6'd14; bus_wdata = 8'h05; bus_we = 1'b1; pin_in[6] = 1'b0;
    step();
    bus_we = 1'b0;
    exp_rd(6'd14, 8'h07, "R10 oe write wins level");
    exp_sig(3, 1'b0, "R10 no error, oe was clear");

    step();
    step();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule